// File: doc/BRIEF.md
# External Interrupt Conditioner

This block takes a group of asynchronous interrupt pins from outside the chip and turns each one into an active-high, level-style request line. The requests feed an on-chip interrupt controller. Each pin is first brought into the clock domain by a two-flop synchronizer.

Software chooses, line by line, level or edge sensing and the active polarity or edge direction. It also masks and unmasks each line and acknowledges latched edge events. All pending lines are presented in parallel on the request vector.

A small synchronous register bus gives access to all of this. Writes take effect at the clock edge that samples them. Reads are combinational from the address. The control registers return zero for bits beyond the number of lines built in, so software can count the lines by writing ones and reading the value back.

Top module: `extirq_cond`

## Requirements
- R1: After reset, the mask, mode, edge-select, level-select and raw status registers all read zero, and `irq_req` is all zero.
- R2: Bit i of `irq_req` is high exactly when line i is pending and unmasked. Several lines may be pending and requesting at the same time.
- R3: With mode bit i set (level sensing), line i is pending while its synchronized pin matches the active level. Level-select bit 1 means active-high and 0 means active-low. A clear write to that line leaves it pending while the level holds.
- R4: With mode bit i clear (edge sensing), a rising edge sets the pending latch of line i when edge-select bit i is 1, and a falling edge sets it when the bit is 0. The opposite edge never sets the latch, and a set latch holds through later pin changes.
- R5: A write to offset 0x04 sets each mask bit that has a one in the data and leaves bits written with zero unchanged. The mask reads back at offset 0x00, where 1 means enabled.
- R6: A write to offset 0x08 clears each mask bit that has a one in the data and leaves bits written with zero unchanged. A line masked this way drives no request from the next cycle on.
- R7: A write to offset 0x0C clears the edge latch of each line that has a one in the data. If a new edge is detected on a line in the same cycle as its clear, the line stays pending.
- R8: The mode (0x14), edge-select (0x18) and level-select (0x1C) registers are read/write. Bit i maps to line i, and bits at or above NUM_LINES always read zero, so an all-ones write to mode reads back as 2^NUM_LINES-1.
- R9: Offset 0x10 returns the raw pending state whatever the mask holds. Reads of offsets 0x04, 0x08 and 0x0C return zero.
- R10: Moving a line into level sensing discards its edge latch, so the latch is clear when the line goes back to edge sensing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_pin | input | NUM_LINES | Asynchronous external interrupt pins |
| irq_req | output | NUM_LINES | Active-high request per line to the interrupt controller |

## Verification
The two functions that can fall in the same cycle are the detection of a fresh edge on a line and a software clear of that line's latch. The bench moves a pin and counts the two synchronizer stages. It then places the clear-register write so that the clock edge sampling the write is also the edge that loads the latch from the newly seen edge, and expects the line to stay pending. A second run places the clear one cycle later and expects the pending state to be gone. This shows that the clear is honoured and that priority goes to the new event, not merely that one of the two outcomes occurred.

// File: rtl/extirq_pkg.sv
`timescale 1ns/100ps
package extirq_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_MASK  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_EN    = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_DIS   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_MODE  = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_EDGE  = 5'h18;
  localparam logic [ADDR_W-1:0] OFF_LEVEL = 5'h1C;

  // Polarity correction: returns 1 when the sample is at the active level.
  function automatic logic level_active(input logic sample, input logic act_high);
    return act_high ? sample : ~sample;
  endfunction

  // Edge test on one line: compares current and previous synchronized sample.
  function automatic logic edge_seen(input logic cur, input logic prev, input logic rising);
    return rising ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Next value of an edge latch; a new edge wins over a clear in the same cycle.
  function automatic logic latch_next(input logic level_mode, input logic hit,
                                      input logic held, input logic clr);
    return level_mode ? 1'b0 : (hit | (held & ~clr));
  endfunction

endpackage

// File: rtl/extirq_sync.sv
`timescale 1ns/100ps
module extirq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic stage1_q;
    logic stage2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q <= 1'b0;
        stage2_q <= 1'b0;
      end else begin
        stage1_q <= async_in[g];
        stage2_q <= stage1_q;
      end
    end
    assign sync_out[g] = stage2_q;
  end

endmodule

// File: rtl/extirq_detect.sv
`timescale 1ns/100ps
module extirq_detect
  import extirq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_in,
  input  logic [WIDTH-1:0] mode_lvl,
  input  logic [WIDTH-1:0] edge_rise,
  input  logic [WIDTH-1:0] lvl_high,
  input  logic [WIDTH-1:0] clr_hit,
  output logic [WIDTH-1:0] edge_hit,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] pending
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_in;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic lvl_on;
    assign lvl_on      = level_active(sync_in[g], lvl_high[g]);
    assign edge_hit[g] = ~mode_lvl[g] & edge_seen(sync_in[g], prev_q[g], edge_rise[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q[g] <= 1'b0;
      else        latch_q[g] <= latch_next(mode_lvl[g], edge_hit[g], latch_q[g], clr_hit[g]);
    end

    assign pending[g] = mode_lvl[g] ? lvl_on : latch_q[g];
  end

endmodule

// File: rtl/extirq_regs.sv
`timescale 1ns/100ps
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [WIDTH-1:0]  pending,
  output logic [WIDTH-1:0]  mask_q,
  output logic [WIDTH-1:0]  mode_q,
  output logic [WIDTH-1:0]  edge_q,
  output logic [WIDTH-1:0]  level_q,
  output logic [WIDTH-1:0]  en_hit,
  output logic [WIDTH-1:0]  dis_hit,
  output logic [WIDTH-1:0]  clr_hit
);

  logic [WIDTH-1:0] wbits;
  assign wbits = bus_wdata[WIDTH-1:0];

  if (WIDTH < DATA_W) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^bus_wdata[DATA_W-1:WIDTH];
  end

  logic wr_en, wr_dis, wr_clr, wr_mode, wr_edge, wr_lvl;
  assign wr_en   = bus_wr && (bus_addr == OFF_EN);
  assign wr_dis  = bus_wr && (bus_addr == OFF_DIS);
  assign wr_clr  = bus_wr && (bus_addr == OFF_CLR);
  assign wr_mode = bus_wr && (bus_addr == OFF_MODE);
  assign wr_edge = bus_wr && (bus_addr == OFF_EDGE);
  assign wr_lvl  = bus_wr && (bus_addr == OFF_LEVEL);

  assign en_hit  = wr_en  ? wbits : '0;
  assign dis_hit = wr_dis ? wbits : '0;
  assign clr_hit = wr_clr ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      mode_q  <= '0;
      edge_q  <= '0;
      level_q <= '0;
    end else begin
      mask_q <= (mask_q | en_hit) & ~dis_hit;
      if (wr_mode) mode_q  <= wbits;
      if (wr_edge) edge_q  <= wbits;
      if (wr_lvl)  level_q <= wbits;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_MASK:  bus_rdata[WIDTH-1:0] = mask_q;
      OFF_STAT:  bus_rdata[WIDTH-1:0] = pending;
      OFF_MODE:  bus_rdata[WIDTH-1:0] = mode_q;
      OFF_EDGE:  bus_rdata[WIDTH-1:0] = edge_q;
      OFF_LEVEL: bus_rdata[WIDTH-1:0] = level_q;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/extirq_cond.sv
`timescale 1ns/100ps
module extirq_cond
  import extirq_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [4:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] ext_pin,
  output logic [NUM_LINES-1:0] irq_req
);

  // Named internal events, brought out for the bound checker.
  logic [NUM_LINES-1:0] sync_pin;
  logic [NUM_LINES-1:0] mask_q, mode_q, edge_q, level_q;
  logic [NUM_LINES-1:0] en_hit, dis_hit, clr_hit;
  logic [NUM_LINES-1:0] edge_hit, latch_q, pending;

  extirq_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_pin),
    .sync_out (sync_pin)
  );

  extirq_detect #(.WIDTH(NUM_LINES)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_pin),
    .mode_lvl  (mode_q),
    .edge_rise (edge_q),
    .lvl_high  (level_q),
    .clr_hit   (clr_hit),
    .edge_hit  (edge_hit),
    .latch_q   (latch_q),
    .pending   (pending)
  );

  extirq_regs #(.WIDTH(NUM_LINES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pending   (pending),
    .mask_q    (mask_q),
    .mode_q    (mode_q),
    .edge_q    (edge_q),
    .level_q   (level_q),
    .en_hit    (en_hit),
    .dis_hit   (dis_hit),
    .clr_hit   (clr_hit)
  );

  assign irq_req = pending & mask_q;

endmodule

// File: rtl/extirq_chk.sv
`timescale 1ns/100ps
module extirq_chk #(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] irq_req,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] mode_q,
  input logic [NUM_LINES-1:0] en_hit,
  input logic [NUM_LINES-1:0] dis_hit,
  input logic [NUM_LINES-1:0] clr_hit,
  input logic [NUM_LINES-1:0] edge_hit,
  input logic [NUM_LINES-1:0] latch_q
);

  a_r5_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_hit) |=> ((mask_q & $past(en_hit)) == $past(en_hit)));

  a_r6_disable_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    (|dis_hit) |=> ((irq_req & $past(dis_hit)) == '0));

  a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((latch_q & $past(edge_hit)) == $past(edge_hit)));

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_hit & ~edge_hit)) |=> ((latch_q & $past(clr_hit & ~edge_hit)) == '0));

  a_r10_level_drops_latch: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((latch_q & $past(mode_q)) == '0));

  always @(negedge clk) begin
    if (rst_n) begin
      a_r8_upper_zero: assert ((bus_rdata >> NUM_LINES) == 32'd0);
    end
  end

endmodule

bind extirq_cond extirq_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rdata (bus_rdata),
  .irq_req   (irq_req),
  .mask_q    (mask_q),
  .mode_q    (mode_q),
  .en_hit    (en_hit),
  .dis_hit   (dis_hit),
  .clr_hit   (clr_hit),
  .edge_hit  (edge_hit),
  .latch_q   (latch_q)
);

// File: tb/sim_extirq_cond.sv
`timescale 1ns/100ps
module sim_extirq_cond;

  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] ext_pin = '0;
  logic [NL-1:0] irq_req;

  always #2 clk = ~clk;

  extirq_cond #(.NUM_LINES(NL)) u0 (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .ext_pin (ext_pin),
    .irq_req (irq_req)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // Monitor: compares queued expectations in the settled part of the cycle.
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? 32'(irq_req) : bus_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk_rd(input logic [4:0] a, input logic [31:0] e, input string t);
    item_t it;
    @(negedge clk); #0.5;
    bus_addr = a;
    it.is_irq = 0; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic chk_irq(input logic [31:0] e, input string t);
    item_t it;
    @(negedge clk); #0.5;
    it.is_irq = 1; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); #0.5;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); #0.5;
    bus_wr = 1'b0;
  endtask

  task automatic set_pins(input logic [NL-1:0] v);
    @(negedge clk); #0.5;
    ext_pin = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    chk_rd(5'h00, 32'h0, "R1 mask");
    chk_rd(5'h14, 32'h0, "R1 mode");
    chk_rd(5'h18, 32'h0, "R1 edge");
    chk_rd(5'h1C, 32'h0, "R1 level");
    chk_rd(5'h10, 32'h0, "R1 status");
    chk_irq(32'h0, "R1 irq");

    // R8 probe of implemented lines
    wr(5'h14, 32'hFFFF_FFFF);
    chk_rd(5'h14, 32'h0000_00FF, "R8 mode probe");
    wr(5'h18, 32'hFFFF_FF5A);
    chk_rd(5'h18, 32'h0000_005A, "R8 edge readback");
    wr(5'h1C, 32'h0000_00A5);
    chk_rd(5'h1C, 32'h0000_00A5, "R8 level readback");
    wr(5'h14, 32'h0); wr(5'h18, 32'h0); wr(5'h1C, 32'h0);

    // R5 / R6 mask set and clear
    wr(5'h04, 32'h0F);
    chk_rd(5'h00, 32'h0F, "R5 enable");
    wr(5'h04, 32'h00);
    chk_rd(5'h00, 32'h0F, "R5 zero write");
    wr(5'h08, 32'h03);
    chk_rd(5'h00, 32'h0C, "R6 disable");
    wr(5'h08, 32'h00);
    chk_rd(5'h00, 32'h0C, "R6 zero write");
    wr(5'h04, 32'hFF);
    chk_rd(5'h04, 32'h0, "R9 enable reads zero");
    chk_rd(5'h0C, 32'h0, "R9 clear reads zero");

    // R4 falling-edge default on line 0
    set_pins(8'h01); idle(4);
    chk_rd(5'h10, 32'h00, "R4 rise ignored when falling");
    set_pins(8'h00); idle(4);
    chk_rd(5'h10, 32'h01, "R4 falling latched");
    chk_irq(32'h01, "R2 irq line0");
    wr(5'h0C, 32'h01);
    chk_rd(5'h10, 32'h00, "R7 clear");

    // R4 rising edge on line 1, held through opposite edge
    wr(5'h18, 32'h02);
    set_pins(8'h02); idle(4);
    chk_rd(5'h10, 32'h02, "R4 rising latched");
    set_pins(8'h00); idle(4);
    chk_rd(5'h10, 32'h02, "R4 latch holds");
    wr(5'h0C, 32'h02);

    // R2 parallel lines, R6 masking, R9 raw status
    wr(5'h18, 32'h0C);
    set_pins(8'h0C); idle(4);
    chk_irq(32'h0C, "R2 two lines");
    wr(5'h08, 32'h04);
    chk_irq(32'h08, "R6 masked line quiet");
    chk_rd(5'h10, 32'h0C, "R9 raw status ignores mask");
    set_pins(8'h00); idle(4);
    wr(5'h0C, 32'h0C);
    chk_rd(5'h10, 32'h00, "R7 clear two");

    // R3 level sensing on lines 4 and 5
    wr(5'h1C, 32'h10);
    wr(5'h14, 32'h10);
    chk_rd(5'h10, 32'h00, "R3 high-active idle");
    set_pins(8'h10); idle(3);
    chk_rd(5'h10, 32'h10, "R3 high level");
    wr(5'h0C, 32'h10);
    chk_rd(5'h10, 32'h10, "R3 clear no effect");
    set_pins(8'h00); idle(3);
    chk_rd(5'h10, 32'h00, "R3 level released");
    wr(5'h14, 32'h30);
    chk_rd(5'h10, 32'h20, "R3 low-active");
    set_pins(8'h30); idle(3);
    chk_rd(5'h10, 32'h10, "R3 both flipped");

    // R7 clear in the same cycle as a new edge on line 6
    set_pins(8'h40); idle(3);
    chk_rd(5'h10, 32'h20, "R4 line6 rise ignored");
    set_pins(8'h00);
    idle(1);
    wr(5'h0C, 32'h40);
    idle(3);
    chk_rd(5'h10, 32'h60, "R7 edge wins over clear");
    chk_irq(32'h60, "R2 irq after collision");
    wr(5'h0C, 32'h40);
    chk_rd(5'h10, 32'h20, "R7 later clear");
    set_pins(8'h40); idle(3);
    set_pins(8'h00);
    idle(2);
    wr(5'h0C, 32'h40);
    idle(3);
    chk_rd(5'h10, 32'h20, "R7 clear after latch");

    // R10 level mode discards the edge latch on line 7
    set_pins(8'h80); idle(3);
    set_pins(8'h00); idle(4);
    chk_rd(5'h10, 32'hA0, "R10 line7 latched");
    wr(5'h1C, 32'h90);
    wr(5'h14, 32'hB0);
    chk_rd(5'h10, 32'h20, "R10 level view");
    wr(5'h14, 32'h30);
    chk_rd(5'h10, 32'h20, "R10 latch gone");

    idle(3);
    done = 1;
    summary();
    $finish;
  end

endmodule